// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns the serial transmit bit of a UART into infrared pulses for the IrDA SIR physical layer. Every transmitted zero becomes one short high pulse on the IR output, and every transmitted one leaves the output low. Bits are framed by a 16x oversampling tick from an external baud generator. Each bit lasts sixteen of these ticks, and the first tick after reset starts a bit.

There are two pulse-width modes. In the baud-relative mode the pulse lasts three sixteenths of the current bit time. In the fixed mode the pulse is timed from a programmable integer divider on the peripheral clock, so its width stays at three sixteenths of a 115.2 kbps bit time whatever baud rate is in use. The divider runs at twice the IR reference clock, with a period of N+1 cycles for a 4-bit code N, so the reference clock is the peripheral clock over 2N+2. For example, a 14.7456 MHz clock with N = 7 gives 921.6 kHz, and the fixed pulse is then 24 cycles, about 1.63 µs.

The block also supplies the clock-enable that drives the external baud generator: the peripheral clock divided by 1, 4, 16 or 64.

Top module: `irPulseEncoder`

## Requirements
- R1: Reset is synchronous and active high. While it is sampled high, and in the cycle after, irOut is 0, and all internal counters return to zero.
- R2: The double-rate reference divider has a period of N+1 clock cycles, where N is divCode. Its first wrap falls in the first cycle after reset.
- R3: A bit starts with pulseSel = 1 and txBit = 0. irOut stays low in the cycle after that bit start. It rises in the cycle after the first divider wrap that follows the bit-start cycle, and it stays high for exactly 3(N+1) cycles.
- R4: A bit starts with pulseSel = 0 and txBit = 0. irOut rises in the cycle after the bit-start tick and stays high for exactly three baud-tick intervals. It falls in the cycle after the third tick that follows.
- R5: A bit that starts with txBit = 1 keeps irOut low for the whole bit, in both modes.
- R6: While the mode latched at bit start is baud-relative, divCode has no effect on irOut.
- R7: A new divCode value is adopted only when the divider wraps. The period in progress is never cut short.
- R8: prescTick is high on every cycle when prescSel = 00, on every 4th cycle for 01, every 16th for 10 and every 64th for 11. Counting from the first cycle after reset as cycle 0, the ticks fall on the cycles whose index modulo the division is the division minus one.
- R9: The mode and the bit value are latched on the bit-start tick, so a change of pulseSel during a bit does not affect that bit's pulse. A new bit start ends any pulse still in progress.
- R10: A bit lasts 16 baud ticks. The first tick after reset begins a bit, and txBit is sampled on that bit-start tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| divCode | input | 4 | Reference divider code N (period N+1 cycles at twice the IR reference) |
| pulseSel | input | 1 | 1 = fixed 115.2 kbps pulse width, 0 = baud-relative width |
| prescSel | input | 2 | Baud generator source division: 00 /1, 01 /4, 10 /16, 11 /64 |
| baudTick | input | 1 | One-cycle 16x baud tick from the external baud generator |
| txBit | input | 1 | UART transmit bit |
| prescTick | output | 1 | Clock-enable for the external baud generator |
| irOut | output | 1 | IR pulse output, active high |

## Verification
Zero/one mixes are sent in both modes at two tick spacings. This shows whether the pulse width follows the tick rate or the divider code, and whether one bits stay quiet. In the fixed mode the divider codes 0, 7 and 15 check the 3(N+1) width at both ends of the code range and at the nominal setting. Other runs change divCode and pulseSel in the middle of a bit, and use a short bit that cuts a long fixed pulse. These separate latching at bit start and adoption at the divider wrap from effects that happen at once. A reference model in the bench follows every cycle, and each prescaler code is counted over a 128-cycle window.

// File: rtl/irPkg.sv
package irPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_PULSE = 2'd2
  } irState_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic irSet;
    logic irClr;
  } irStrobe_t;

  // Events reported from datapath to control
  typedef struct packed {
    logic tick2x;
    logic bitStart;
    logic pulseLast;
  } irStatus_t;

endpackage

// File: rtl/irPrescaler.sv
module irPrescaler #(
  parameter int STEP   = 2,
  parameter int LEVELS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(LEVELS)-1:0] sel,
  output logic                      tick
);
  localparam int CNT_W = STEP * (LEVELS - 1);

  logic [CNT_W-1:0]  preCnt;
  logic [LEVELS-1:0] levelTick;

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + 1'b1;
  end

  // Level k divides by 2^(STEP*k)
  generate
    for (genvar k = 0; k < LEVELS; k++) begin : g_level
      if (k == 0) begin : g_raw
        assign levelTick[k] = 1'b1;
      end else begin : g_div
        assign levelTick[k] = &preCnt[k*STEP-1:0];
      end
    end
  endgenerate

  assign tick = levelTick[sel];

  // R8: the shared counter rolls over to zero
  p_presc_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (preCnt == '1) |=> (preCnt == '0));

endmodule

// File: rtl/irDatapath.sv
module irDatapath
  import irPkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int PH_W        = 4,
  parameter int PULSE_TICKS = 3,
  parameter int PRE_STEP    = 2,
  parameter int PRE_LEVELS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DIV_W-1:0]              divCode,
  input  logic [$clog2(PRE_LEVELS)-1:0] prescSel,
  input  logic                          baudTick,
  input  irStrobe_t                     stb,
  output irStatus_t                     st,
  output logic                          prescTick,
  output logic                          irOut
);
  localparam int CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_TICKS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] pulseCnt;
  logic             irReg;
  logic             tick2x;

  // Double-rate reference divider; the new code is taken only at a wrap
  assign tick2x = (divCnt == divLimit);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      divLimit <= '0;
    end else if (tick2x) begin
      divCnt   <= '0;
      divLimit <= divCode;
    end else begin
      divCnt   <= divCnt + 1'b1;
    end
  end

  // Bit framing: one bit per 2^PH_W baud ticks
  always_ff @(posedge clk) begin
    if (rst)           phase <= '0;
    else if (baudTick) phase <= phase + 1'b1;
  end

  // Pulse length counter
  always_ff @(posedge clk) begin
    if (rst || stb.cntClr) pulseCnt <= '0;
    else if (stb.cntInc)   pulseCnt <= pulseCnt + 1'b1;
  end

  // Output register; set wins over clear
  always_ff @(posedge clk) begin
    if (rst)            irReg <= 1'b0;
    else if (stb.irSet) irReg <= 1'b1;
    else if (stb.irClr) irReg <= 1'b0;
  end

  irPrescaler #(
    .STEP  (PRE_STEP),
    .LEVELS(PRE_LEVELS)
  ) u_presc (
    .clk (clk),
    .rst (rst),
    .sel (prescSel),
    .tick(prescTick)
  );

  assign st.tick2x    = tick2x;
  assign st.bitStart  = baudTick && (phase == '0);
  assign st.pulseLast = (pulseCnt == CNT_LAST);
  assign irOut        = irReg;

  // R2: the divider count never passes its limit
  p_div_bound_r2: assert property (@(posedge clk) disable iff (rst)
    divCnt <= divLimit);

  // R7: the limit holds between wraps
  p_limit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tick2x |=> $stable(divLimit));

  // R3: the pulse counter stays in range
  p_pulse_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    pulseCnt <= CNT_LAST);

endmodule

// File: rtl/irControl.sv
module irControl
  import irPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pulseSel,
  input  logic      txBit,
  input  logic      baudTick,
  input  irStatus_t st,
  output irStrobe_t stb
);
  irState_e state, stateN;
  logic     fixedMode, fixedModeN;
  logic     pulseEvent;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fixedMode <= 1'b0;
    end else begin
      state     <= stateN;
      fixedMode <= fixedModeN;
    end
  end

  assign pulseEvent = fixedMode ? st.tick2x : baudTick;

  always_comb begin
    stb        = '0;
    stateN     = state;
    fixedModeN = fixedMode;
    if (st.bitStart) begin
      // New bit: latch the mode and end any pulse still running
      fixedModeN = pulseSel;
      stb.irClr  = 1'b1;
      stb.cntClr = 1'b1;
      if (!txBit) begin
        if (pulseSel) begin
          stateN = ST_ARM;
        end else begin
          stateN    = ST_PULSE;
          stb.irSet = 1'b1;
        end
      end else begin
        stateN = ST_IDLE;
      end
    end else begin
      case (state)
        ST_ARM: begin
          if (st.tick2x) begin
            stateN     = ST_PULSE;
            stb.irSet  = 1'b1;
            stb.cntClr = 1'b1;
          end
        end
        ST_PULSE: begin
          if (pulseEvent) begin
            if (st.pulseLast) begin
              stb.irClr = 1'b1;
              stateN    = ST_IDLE;
            end else begin
              stb.cntInc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3: waiting for a divider wrap only happens in fixed mode
  p_arm_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARM) |-> fixedMode);

  // R9: only encoded states are reachable
  p_state_legal_r9: assert property (@(posedge clk) disable iff (rst)
    state != irState_e'(2'd3));

endmodule

// File: rtl/irPulseEncoder.sv
module irPulseEncoder
  import irPkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int PH_W        = 4,
  parameter int PULSE_TICKS = 3,
  parameter int PRE_STEP    = 2,
  parameter int PRE_LEVELS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DIV_W-1:0]              divCode,
  input  logic                          pulseSel,
  input  logic [$clog2(PRE_LEVELS)-1:0] prescSel,
  input  logic                          baudTick,
  input  logic                          txBit,
  output logic                          prescTick,
  output logic                          irOut
);
  irStrobe_t stb;
  irStatus_t st;

  irDatapath #(
    .DIV_W      (DIV_W),
    .PH_W       (PH_W),
    .PULSE_TICKS(PULSE_TICKS),
    .PRE_STEP   (PRE_STEP),
    .PRE_LEVELS (PRE_LEVELS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .divCode  (divCode),
    .prescSel (prescSel),
    .baudTick (baudTick),
    .stb      (stb),
    .st       (st),
    .prescTick(prescTick),
    .irOut    (irOut)
  );

  irControl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .pulseSel(pulseSel),
    .txBit   (txBit),
    .baudTick(baudTick),
    .st      (st),
    .stb     (stb)
  );

  // R1: output low after a reset cycle
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !irOut);

  // R5: a one bit gives no pulse
  p_one_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (st.bitStart && txBit) |=> !irOut);

  // R4: baud-relative pulse starts right after the bit-start tick
  p_baud_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (st.bitStart && !txBit && !pulseSel) |=> irOut);

  // R3: fixed pulse waits for a later divider wrap
  p_fixed_defer_r3: assert property (@(posedge clk) disable iff (rst)
    (st.bitStart && !txBit && pulseSel) |=> !irOut);

endmodule

// File: tb/irPulseEncoder_test.sv
`timescale 1ns/1ps
module irPulseEncoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] divCode = 4'd0;
  logic       pulseSel = 1'b0;
  logic [1:0] prescSel = 2'd0;
  logic       baudTick = 1'b0;
  logic       txBit = 1'b1;
  logic       prescTick;
  logic       irOut;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curReq = "R1";
  bit    checking = 1'b0;
  int    highCount = 0;
  int    lastSnap = 0;
  int    pendExp = -1;
  string pendReq = "";

  // Reference model state
  int mDc, mDl, mPhase, mLeft, mCyc;
  bit mArmed, mOn, mFixed;

  irPulseEncoder uut (
    .clk      (clk),
    .rst      (rst),
    .divCode  (divCode),
    .pulseSel (pulseSel),
    .prescSel (prescSel),
    .baudTick (baudTick),
    .txBit    (txBit),
    .prescTick(prescTick),
    .irOut    (irOut)
  );

  always #2.5 clk = ~clk;

  function automatic void checkBit(input logic act, input logic exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic void checkInt(input int act, input int exp, input string req);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endfunction

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit t2;
    bit bs;
    if (rst) begin
      mDc = 0; mDl = 0; mPhase = 0; mLeft = 0; mCyc = 0;
      mArmed = 0; mOn = 0; mFixed = 0;
    end else begin
      t2 = (mDc == mDl);
      bs = baudTick && (mPhase == 0);          // R10 framing
      if (bs) begin
        mFixed = pulseSel;
        mArmed = 0; mOn = 0;
        if (!txBit) begin
          if (pulseSel) mArmed = 1;
          else begin mOn = 1; mLeft = 3; end
        end
      end else if (mArmed && t2) begin
        mArmed = 0; mOn = 1; mLeft = 3;
      end else if (mOn && (mFixed ? t2 : baudTick)) begin
        mLeft--;
        if (mLeft == 0) mOn = 0;
      end
      if (t2) begin mDc = 0; mDl = int'(divCode); end
      else mDc++;
      if (baudTick) mPhase = (mPhase + 1) % 16;
      mCyc++;
    end
  end

  // Compare against the model away from the rising edge
  always @(negedge clk) begin
    int d;
    if (checking) begin
      checkBit(irOut, mOn, curReq);
      d = 1 << (2 * int'(prescSel));
      checkBit(prescTick, (mCyc % d) == d - 1, "R8");
      if (irOut === 1'b1) highCount++;
    end
  end

  task automatic settleBit(input int exp, input string req);
    if (pendExp >= 0) checkInt(highCount - lastSnap, pendExp, pendReq);
    lastSnap = highCount;
    pendExp  = exp;
    pendReq  = req;
  endtask

  // One bit of 16 ticks spaced per cycles; exp < 0 skips the width count
  task automatic sendBit(input bit b, input int per, input int exp, input string req,
                         input int chgAt = -1, input logic [3:0] newDiv = 4'd0,
                         input int flipAt = -1);
    curReq = req;
    txBit  = b;
    for (int t = 0; t < 16; t++) begin
      for (int c = 0; c < per; c++) begin
        if (t * per + c == chgAt)  divCode  = newDiv;
        if (t * per + c == flipAt) pulseSel = ~pulseSel;
        baudTick = (c == 0);
        @(posedge clk);
        if (t == 0 && c == 0) settleBit(exp, req);
        #1;
      end
    end
    baudTick = 1'b0;
  endtask

  task automatic flushBits(input int n);
    baudTick = 1'b0;
    txBit    = 1'b1;
    repeat (n) begin @(posedge clk); #1; end
    @(posedge clk);
    settleBit(-1, "");
    #1;
  endtask

  initial begin
    #(100000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset state
    @(posedge clk); #1;
    checking = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    @(negedge clk);
    checkBit(irOut, 1'b0, "R1");
    @(posedge clk); #1;
    rst = 1'b0;

    // R4 / R5 / R10: baud-relative mode, 4-cycle ticks
    pulseSel = 1'b0;
    sendBit(1'b0, 4, 12, "R10");
    sendBit(1'b1, 4, 0,  "R5");
    sendBit(1'b0, 4, 12, "R4");
    sendBit(1'b0, 4, 12, "R4");
    sendBit(1'b1, 4, 0,  "R5");
    sendBit(1'b0, 6, 18, "R4");

    // R6: divider code changes have no effect in baud mode
    divCode = 4'd15;
    sendBit(1'b0, 4, 12, "R6", 3, 4'd9);
    sendBit(1'b0, 4, 12, "R6", 1, 4'd2);

    // R9: pulseSel flips mid-bit; this bit stays baud-relative
    sendBit(1'b0, 6, 18, "R9", -1, 4'd0, 2);

    // R3: fixed mode, N = 7 gives 24 cycles
    divCode = 4'd7;
    sendBit(1'b0, 6, 24, "R3");
    sendBit(1'b1, 6, 0,  "R5");
    sendBit(1'b0, 6, 24, "R3");
    divCode = 4'd15;
    sendBit(1'b0, 6, 48, "R3");
    divCode = 4'd0;
    sendBit(1'b0, 6, 3,  "R2");

    // R7: code change during a pulse, then settled width for N = 5
    divCode = 4'd3;
    sendBit(1'b0, 6, -2, "R7", 20, 4'd5);
    sendBit(1'b0, 6, 18, "R7");

    // R9: short bits cut a long fixed pulse
    divCode = 4'd15;
    sendBit(1'b0, 6, 48, "R3");
    sendBit(1'b0, 2, -2, "R9");
    sendBit(1'b1, 2, 0,  "R9");
    flushBits(40);

    // R8: prescaler rates over 128 cycles
    curReq = "R8";
    for (int s = 0; s < 4; s++) begin
      int cnt;
      cnt = 0;
      prescSel = 2'(s);
      for (int i = 0; i < 128; i++) begin
        @(negedge clk);
        if (prescTick === 1'b1) cnt++;
      end
      checkInt(cnt, 128 >> (2 * s), "R8");
      @(posedge clk); #1;
    end

    // R1: reset during a baud-relative pulse
    curReq = "R1";
    pulseSel = 1'b0;
    txBit = 1'b0;
    baudTick = 1'b1;
    @(posedge clk); #1;
    baudTick = 1'b0;
    @(negedge clk);
    checkBit(irOut, 1'b1, "R4");
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    checkBit(irOut, 1'b0, "R1");
    @(posedge clk); #1;

    checking = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule